// File: doc/BRIEF.md
# Calendar Alarm Field Matcher

This block holds a four-field calendar alarm (minute, hour, day of month, day of week) and compares it with the running calendar time that a separate timekeeping counter supplies in BCD. Each field carries its own active-low include bit, so software can build alarms such as "every day at 07:30" or "every Monday" by leaving the other fields out. The alarm has no seconds field. It can only fire at the instant the seconds value rolls over to 00.

When every included field equals the current time at that rollover, a sticky alarm flag is set. Software clears the flag by writing a zero to its bit. An interrupt request output is the flag gated by a software enable bit. Software reaches the registers through a simple write strobe with an address and a data byte. The bus bridge that produces those strobes, the time counters and the shared interrupt pin driver sit outside this block.

Top module: `cal_alarm_match`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), alarm_flag and alarm_irq are 0, the interrupt enable is 0, and all four alarm fields are excluded with value 0.
- R2: A write to address 0x0A, 0x0B, 0x0C or 0x0D loads the minute, hour, day-of-month or day-of-week field respectively. Data bit 7 is the include bit, active low (0 = compared, 1 = left out). The value bits are [6:0] for minute, [5:0] for hour and day of month, and [2:0] for day of week. The remaining data bits are ignored.
- R3: A match requires every included field to equal the matching current-time input, and an excluded field never prevents a match.
- R4: When all four fields are excluded, the flag is never set, whatever the time.
- R5: The flag is set only at the clock edge where cur_sec is 0x00 while its value at the previous edge was non-zero, and only if the fields match at that edge. A match while the seconds are non-zero, or while they stay at 0x00, does not set the flag.
- R6: Once set, the flag stays set until a write to address 0x01 with data bit 3 equal to 0 clears it. A write to 0x01 with bit 3 equal to 1 leaves the flag unchanged.
- R7: If a clearing write and a setting rollover happen at the same edge, the flag ends up set.
- R8: alarm_irq is 1 exactly when the flag is 1 and the interrupt enable is 1. The enable is data bit 1 of the last write to address 0x00.
- R9: Writes to any address other than 0x00, 0x01 and 0x0A to 0x0D change no state.
- R10: A field or enable written at one edge takes part in the comparison and gating from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Flag gated by the interrupt enable |

## Verification
The two functions that can meet in one cycle are the setting of the flag by a matching seconds rollover and its clearing by a software write of zero to the flag bit. The bench provokes this by driving the rollover to 0x00 and the clearing write in the same cycle, both after a matching setup. It judges the result by the flag sampled after that edge, which must read 1. The constrained-random phase also mixes clearing writes with rollovers, so the collision appears again at random alignments and is compared with the bench's own model.

// File: rtl/cam_pkg.sv
// Shared constants and helpers for the calendar alarm matcher.
// Assumes four fields stored padded to a common width.
package cam_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int VAL_W      = 7;
    localparam int DATA_W     = 8;

    typedef enum int {
        FLD_MIN  = 0,
        FLD_HOUR = 1,
        FLD_DATE = 2,
        FLD_WDAY = 3
    } field_e;

    // Number of significant value bits of each field.
    function automatic int field_width(int idx);
        case (idx)
            FLD_MIN:  return 7;
            FLD_HOUR: return 6;
            FLD_DATE: return 6;
            default:  return 3;
        endcase
    endfunction

    // Mask selecting the significant value bits of each field.
    function automatic logic [VAL_W-1:0] field_mask(int idx);
        return VAL_W'((1 << field_width(idx)) - 1);
    endfunction
endpackage

// File: rtl/cam_regs.sv
// Alarm field, enable and clear decode for the alarm matcher.
// Assumes one write per cycle. Field values are masked on write.
module cam_regs #(
    parameter int ADDR_W     = 5,
    parameter int EN_ADDR    = 0,
    parameter int FLAG_ADDR  = 1,
    parameter int FIELD_BASE = 10,
    parameter int EN_BIT     = 1,
    parameter int FLAG_BIT   = 3,
    parameter int EXCL_BIT   = 7
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic [ADDR_W-1:0]                             wr_addr,
    input  logic [cam_pkg::DATA_W-1:0]                    wr_data,
    output logic [cam_pkg::NUM_FIELDS-1:0][cam_pkg::VAL_W-1:0] alarm_val,
    output logic [cam_pkg::NUM_FIELDS-1:0]                excl,
    output logic                                          irq_en,
    output logic                                          clr_req
);
    import cam_pkg::*;

    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (wr_en && wr_addr == EN_A)
            irq_en <= wr_data[EN_BIT];
    end

    // Clearing request: write of zero to the flag bit.
    always_comb clr_req = wr_en && (wr_addr == FLAG_A) && !wr_data[FLAG_BIT];

    // One register per alarm field.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] FA   = ADDR_W'(FIELD_BASE + i);
        localparam logic [VAL_W-1:0]  MASK = field_mask(i);

        // Load include bit and masked value on a write to this field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                excl[i]      <= 1'b1;
                alarm_val[i] <= '0;
            end else if (wr_en && wr_addr == FA) begin
                excl[i]      <= wr_data[EXCL_BIT];
                alarm_val[i] <= wr_data[VAL_W-1:0] & MASK;
            end
        end
    end
endmodule

// File: rtl/cam_tick.sv
// Detects the rollover of the seconds value to zero.
// Assumes cur_sec is stable around the clock edge.
module cam_tick #(
    parameter int SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cur_sec,
    output logic             tick
);
    logic [SEC_W-1:0] prev_sec;

    // Remember the seconds value seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_sec <= '0;
        else
            prev_sec <= cur_sec;
    end

    // Rollover: zero now, non-zero before.
    always_comb tick = (cur_sec == '0) && (prev_sec != '0);

    a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cam_compare.sv
// Field comparator: every included field must equal the current time.
// Assumes inputs padded with zeros above each field width.
module cam_compare (
    input  logic [cam_pkg::NUM_FIELDS-1:0][cam_pkg::VAL_W-1:0] alarm_val,
    input  logic [cam_pkg::NUM_FIELDS-1:0][cam_pkg::VAL_W-1:0] cur_val,
    input  logic [cam_pkg::NUM_FIELDS-1:0]                excl,
    output logic                                          match,
    output logic                                          none_incl
);
    import cam_pkg::*;

    logic [NUM_FIELDS-1:0] hit;

    // Per-field hit: excluded, or masked values equal.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam logic [VAL_W-1:0] MASK = field_mask(i);
        always_comb hit[i] = excl[i] || ((alarm_val[i] & MASK) == (cur_val[i] & MASK));
    end

    // Overall match needs at least one included field.
    always_comb begin
        none_incl = &excl;
        match     = !none_incl && (&hit);
    end
endmodule

// File: rtl/cam_flag.sv
// Sticky alarm flag with software clear and gated interrupt.
// Assumes set and clear requests are single-cycle.
module cam_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Set on a matching rollover; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tick && match)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    // Interrupt request follows the flag when enabled.
    always_comb irq = flag && irq_en;

    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick && match));
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_req));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match && clr_req) |=> flag);
endmodule

// File: rtl/cal_alarm_match.sv
// Top of the calendar alarm matcher: registers, rollover detect,
// comparator and sticky flag. Assumes BCD time from an external counter.
module cal_alarm_match #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_date,
    input  logic [2:0]        cur_wday,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    import cam_pkg::*;

    logic [NUM_FIELDS-1:0][VAL_W-1:0] alarm_val;
    logic [NUM_FIELDS-1:0][VAL_W-1:0] cur_val;
    logic [NUM_FIELDS-1:0]            excl;
    logic irq_en, clr_req, tick, match, none_incl;

    // Pack current time fields to the common width.
    always_comb begin
        cur_val[FLD_MIN]  = cur_min;
        cur_val[FLD_HOUR] = {1'b0, cur_hour};
        cur_val[FLD_DATE] = {1'b0, cur_date};
        cur_val[FLD_WDAY] = {4'b0, cur_wday};
    end

    cam_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alarm_val(alarm_val), .excl(excl),
        .irq_en(irq_en), .clr_req(clr_req)
    );

    cam_tick #(.SEC_W(7)) u_tick (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .tick(tick)
    );

    cam_compare u_cmp (
        .alarm_val(alarm_val), .cur_val(cur_val), .excl(excl),
        .match(match), .none_incl(none_incl)
    );

    cam_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
        .clr_req(clr_req), .irq_en(irq_en), .flag(alarm_flag), .irq(alarm_irq)
    );

    a_r4_none_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        none_incl |-> !match);
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !alarm_irq);
endmodule

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [6:0] cur_sec = 0, cur_min = 0;
    logic [5:0] cur_hour = 0, cur_date = 0;
    logic [2:0] cur_wday = 0;
    logic       wr_en = 0;
    logic [4:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       alarm_flag, alarm_irq;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model state
    logic [6:0] m_val [4];
    logic       m_excl [4];
    logic       m_en, m_flag;
    logic [6:0] m_prev;

    always #5 clk = ~clk;

    cal_alarm_match u_cal_alarm_match (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    function automatic logic [6:0] fmask(int i);
        case (i)
            0: return 7'h7F;
            1, 2: return 7'h3F;
            default: return 7'h07;
        endcase
    endfunction

    function automatic logic model_match();
        logic [6:0] cv [4];
        logic any = 0, all = 1;
        cv[0] = cur_min; cv[1] = {1'b0, cur_hour};
        cv[2] = {1'b0, cur_date}; cv[3] = {4'b0, cur_wday};
        for (int i = 0; i < 4; i++) begin
            if (!m_excl[i]) begin
                any = 1;
                if ((cv[i] & fmask(i)) != m_val[i]) all = 0;
            end
        end
        return any && all;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_excl[i] = 1; end
        m_en = 0; m_flag = 0; m_prev = 0;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update model at edge, check outputs at falling edge
    task automatic step(input string tag);
        logic tk, st, cl;
        @(posedge clk);
        tk = (cur_sec == 0) && (m_prev != 0);
        st = tk && model_match();
        cl = wr_en && wr_addr == 5'h01 && !wr_data[3];
        if (st) m_flag = 1; else if (cl) m_flag = 0;
        if (wr_en) begin
            if (wr_addr == 5'h00) m_en = wr_data[1];
            for (int i = 0; i < 4; i++)
                if (wr_addr == 5'(10 + i)) begin
                    m_excl[i] = wr_data[7];
                    m_val[i]  = wr_data[6:0] & fmask(i);
                end
        end
        m_prev = cur_sec;
        @(negedge clk);
        wr_en = 0;
        chk({tag, " flag"}, alarm_flag, m_flag);
        chk({tag, " irq"}, alarm_irq, m_flag & m_en);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(tag);
    endtask

    task automatic set_time(input logic [6:0] mi, input logic [5:0] h,
                            input logic [5:0] d, input logic [2:0] w);
        cur_min = mi; cur_hour = h; cur_date = d; cur_wday = w;
    endtask

    // roll the seconds 59 -> 00
    task automatic roll(input string tag);
        cur_sec = 7'h59; step(tag);
        cur_sec = 7'h00; step(tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset flag", alarm_flag, 1'b0);
        chk("R1 reset irq", alarm_irq, 1'b0);
        rst_n = 1;
        set_time(7'h00, 6'h00, 6'h00, 3'd0);
        roll("R1 all excluded after reset");
        chk("R1 no alarm", alarm_flag, 1'b0);

        // R2/R3: minute only
        set_time(7'h30, 6'h07, 6'h15, 3'd2);
        wr(5'h0A, 8'h30, "R2 write minute");
        roll("R3 minute match");
        chk("R3 minute fired", alarm_flag, 1'b1);
        chk("R8 irq off without enable", alarm_irq, 1'b0);

        // R6 write-one keeps, write-zero clears
        wr(5'h01, 8'h08, "R6 write one keeps");
        chk("R6 kept", alarm_flag, 1'b1);
        wr(5'h01, 8'hF7, "R6 write zero clears");
        chk("R6 cleared", alarm_flag, 1'b0);
        // R5 seconds held at zero: no re-set
        step("R5 held zero");
        chk("R5 no repeat", alarm_flag, 1'b0);
        // R5 match while seconds non-zero
        cur_sec = 7'h12; step("R5 mid minute");
        cur_sec = 7'h13; step("R5 mid minute");
        chk("R5 no mid fire", alarm_flag, 1'b0);

        // R8 enable gating, R10 enable timing
        wr(5'h00, 8'h02, "R8 enable");
        roll("R8 roll");
        chk("R8 irq set", alarm_irq, 1'b1);
        wr(5'h00, 8'hFD, "R8 disable");
        chk("R8 irq off", alarm_irq, 1'b0);
        chk("R8 flag stays", alarm_flag, 1'b1);
        wr(5'h01, 8'h00, "R6 clear");

        // R7 collision
        cur_sec = 7'h59; step("R7 prep");
        cur_sec = 7'h00; wr_en = 1; wr_addr = 5'h01; wr_data = 8'h00;
        step("R7 set and clear");
        chk("R7 set wins", alarm_flag, 1'b1);
        wr(5'h01, 8'h00, "R6 clear");

        // R4 all excluded but values equal
        wr(5'h0A, 8'hB0, "R4 excl min");
        wr(5'h0B, 8'h87, "R4 excl hour");
        wr(5'h0C, 8'h95, "R4 excl date");
        wr(5'h0D, 8'h82, "R4 excl wday");
        roll("R4 roll");
        chk("R4 no fire", alarm_flag, 1'b0);

        // R3 mismatch on one included field; R2 ignored bit 6 of hour
        wr(5'h0B, 8'h47, "R2 hour with bit6");
        wr(5'h0A, 8'h31, "R3 min mismatch");
        roll("R3 mismatch roll");
        chk("R3 mismatch no fire", alarm_flag, 1'b0);
        wr(5'h0A, 8'hB1, "R3 drop minute");
        roll("R2 hour only roll");
        chk("R2 hour masked match", alarm_flag, 1'b1);
        wr(5'h01, 8'h00, "R6 clear");

        // R9 other addresses ignored
        wr(5'h0B, 8'h87, "R9 excl hour");
        set_time(7'h00, 6'h00, 6'h00, 3'd0);
        wr(5'h05, 8'h00, "R9 junk");
        wr(5'h0E, 8'h00, "R9 junk");
        wr(5'h1F, 8'h00, "R9 junk");
        wr(5'h09, 8'h00, "R9 junk");
        roll("R9 roll");
        chk("R9 no fire", alarm_flag, 1'b0);

        // random phase checked against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] v;
            r = $urandom % 9;
            if ($urandom % 8 == 0)
                set_time(($urandom % 2) ? 7'h05 : 7'h30, ($urandom % 2) ? 6'h07 : 6'h23,
                         ($urandom % 2) ? 6'h01 : 6'h31, ($urandom % 2) ? 3'd2 : 3'd6);
            cur_sec = ($urandom % 3 == 0) ? 7'h00 : 7'h59;
            if (r < 3) begin
                int f;
                f = $urandom % 4;
                case (f)
                    0: v = ($urandom % 2) ? 8'h05 : 8'h30;
                    1: v = ($urandom % 2) ? 8'h07 : 8'h63;
                    2: v = ($urandom % 2) ? 8'h01 : 8'h31;
                    default: v = ($urandom % 2) ? 8'h02 : 8'h76;
                endcase
                if ($urandom % 10 < 3) v[7] = 1;
                wr_en = 1; wr_addr = 5'(10 + f); wr_data = v;
            end else if (r == 3) begin
                wr_en = 1; wr_addr = 5'h00; wr_data = 8'($urandom);
            end else if (r == 4) begin
                wr_en = 1; wr_addr = 5'h01; wr_data = 8'($urandom);
            end else if (r == 5) begin
                wr_en = 1; wr_addr = 5'(14 + $urandom % 18); wr_data = 8'($urandom);
            end
            step("R3 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule